// File: doc/BRIEF.md
# 100 Mb/s Nibble-to-Code-Group Framer

This block sits between a 4-bit media-independent nibble interface and a 5-bit code-group stream, one nibble or one code group per clock. On the transmit side it turns a frame delimited by a transmit enable into a code-group stream. The stream is a start delimiter pair in place of the first preamble octet, then 4B/5B encoded data, then an end delimiter pair, with IDLE filling every gap. A transmit error input forces the error code group in data positions.

On the receive side it watches the incoming code groups for the start delimiter. It then raises carrier sense and data valid, and returns decoded nibbles. It closes the frame on the end delimiter, on a premature IDLE, or carries on with an error flag when an invalid symbol shows up. Scrambling, line coding and clock recovery belong to neighbouring blocks. Both directions register their outputs, so each output reflects the input sampled at the same rising edge, one clock of latency.

Top module: `pcs_framer`

## Requirements
- R1: After reset the transmit code is IDLE (11111) and carrier sense, data valid, receive error and receive nibble are all 0. IDLE is sent on every clock while transmit enable is low and no end delimiter is pending. Every output takes the value implied by the inputs sampled at the same rising edge.
- R2: When transmit enable rises from the idle state, the first two nibbles are replaced by J (11000) and then K (10001), always as a pair.
- R3: In data positions a nibble is sent as its 4B/5B code group. The codes for nibbles 0 through F are: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R4: A data position whose transmit error input is high sends H (00100) instead of the data code.
- R5: The first clock with transmit enable low after data sends T (01101), the next sends R (00111), and IDLE follows. A new frame starts only from the idle state.
- R6: A received J outside a frame raises carrier sense and data valid with receive nibble 0101. A following K gives another 0101 with both flags still high.
- R7: A data code inside a frame gives its decoded nibble (same table as R3), with data valid and carrier sense high and receive error low.
- R8: A received T inside a frame lowers carrier sense and data valid with no receive error. The R that follows is absorbed, and outputs stay 0.
- R9: IDLE inside a frame, without a preceding T, lowers carrier sense and data valid and raises receive error for exactly one clock.
- R10: Inside a frame, any code that is neither a data code, T nor IDLE raises receive error for that clock, with carrier sense and data valid high and nibble 0000. The frame continues. Directly after J, anything other than K counts this way, a data code included.
- R11: Outside a frame, every code other than J leaves all receive outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one nibble and one code group per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmit enable from the MAC |
| txEr | input | 1 | Transmit error from the MAC |
| txd | input | 4 | Transmit nibble |
| txCode | output | 5 | Transmit code group |
| rxCode | input | 5 | Received code group |
| crs | output | 1 | Carrier sense |
| rxDv | output | 1 | Receive data valid |
| rxEr | output | 1 | Receive error |
| rxd | output | 4 | Receive nibble |

## Verification
The embedded properties check the pairing rules on every clock: J is always followed by K, and T always by R. They also check that a premature-end error lasts a single clock, that data valid never stands without carrier sense, and that an idle line with enable low stays idle. The exact encoding of every nibble, the H substitution, the decode of all 32 received code values inside and outside a frame, and the framing around a non-K after J show only in the bench's sweeps.

// File: rtl/pcs_framer_pkg.sv
package pcs_framer_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;
  localparam int NUM_DATA = 1 << NIB_W;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

  localparam logic [CODE_W-1:0] C_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] C_J    = 5'b11000;
  localparam logic [CODE_W-1:0] C_K    = 5'b10001;
  localparam logic [CODE_W-1:0] C_T    = 5'b01101;
  localparam logic [CODE_W-1:0] C_R    = 5'b00111;
  localparam logic [CODE_W-1:0] C_H    = 5'b00100;

  typedef enum logic [2:0] {
    TXO_IDLE, TXO_J, TXO_K, TXO_DATA, TXO_ERR, TXO_T, TXO_R
  } txSel_e;

  typedef enum logic [2:0] {
    RXO_NONE, RXO_PRE, RXO_DATA, RXO_BAD, RXO_EARLY
  } rxSel_e;

  typedef struct packed {
    txSel_e txSel;
    rxSel_e rxSel;
  } strobes_t;

  typedef struct packed {
    logic isJ;
    logic isK;
    logic isT;
    logic isIdle;
    logic isData;
  } rxClass_t;

  function automatic logic [CODE_W-1:0] encNib(input logic [NIB_W-1:0] n);
    logic [CODE_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110; 4'h1: c = 5'b01001; 4'h2: c = 5'b10100; 4'h3: c = 5'b10101;
      4'h4: c = 5'b01010; 4'h5: c = 5'b01011; 4'h6: c = 5'b01110; 4'h7: c = 5'b01111;
      4'h8: c = 5'b10010; 4'h9: c = 5'b10011; 4'hA: c = 5'b10110; 4'hB: c = 5'b10111;
      4'hC: c = 5'b11010; 4'hD: c = 5'b11011; 4'hE: c = 5'b11100; default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pcs_framer_ctrl.sv
module pcs_framer_ctrl
  import pcs_framer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txEn,
  input  logic     txEr,
  input  rxClass_t rxClass,
  output strobes_t strobes
);
  typedef enum logic [1:0] {TXS_IDLE, TXS_K, TXS_DATA, TXS_R} txState_e;
  typedef enum logic [1:0] {RXS_IDLE, RXS_K, RXS_DATA, RXS_R} rxState_e;

  txState_e txState, txNext;
  rxState_e rxState, rxNext;

  always_comb begin
    txNext        = txState;
    strobes.txSel = TXO_IDLE;
    case (txState)
      TXS_IDLE: if (txEn) begin
        strobes.txSel = TXO_J;
        txNext        = TXS_K;
      end
      TXS_K: begin
        strobes.txSel = TXO_K;
        txNext        = TXS_DATA;
      end
      TXS_DATA: if (txEn) begin
        strobes.txSel = txEr ? TXO_ERR : TXO_DATA;
      end else begin
        strobes.txSel = TXO_T;
        txNext        = TXS_R;
      end
      default: begin
        strobes.txSel = TXO_R;
        txNext        = TXS_IDLE;
      end
    endcase
  end

  always_comb begin
    rxNext        = rxState;
    strobes.rxSel = RXO_NONE;
    case (rxState)
      RXS_IDLE: if (rxClass.isJ) begin
        strobes.rxSel = RXO_PRE;
        rxNext        = RXS_K;
      end
      RXS_K, RXS_DATA: begin
        rxNext = RXS_DATA;
        if (rxClass.isT) begin
          strobes.rxSel = RXO_NONE;
          rxNext        = RXS_R;
        end else if (rxClass.isIdle) begin
          strobes.rxSel = RXO_EARLY;
          rxNext        = RXS_IDLE;
        end else if (rxState == RXS_K && rxClass.isK) begin
          strobes.rxSel = RXO_PRE;
        end else if (rxState == RXS_DATA && rxClass.isData) begin
          strobes.rxSel = RXO_DATA;
        end else begin
          strobes.rxSel = RXO_BAD;
        end
      end
      default: rxNext = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TXS_IDLE;
      rxState <= RXS_IDLE;
    end else begin
      txState <= txNext;
      rxState <= rxNext;
    end
  end

  AST_DELIM_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TXS_DATA && !txEn) |=> (txState == TXS_R)); // R5
endmodule

// File: rtl/pcs_framer_dp.sv
module pcs_framer_dp
  import pcs_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  txd,
  input  logic [CODE_W-1:0] rxCode,
  input  strobes_t          strobes,
  output rxClass_t          rxClass,
  output logic [CODE_W-1:0] txCode,
  output logic              crs,
  output logic              rxDv,
  output logic              rxEr,
  output logic [NIB_W-1:0]  rxd
);
  logic [NIB_W-1:0] decNib;
  logic [NUM_DATA-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DATA; gi++) begin : g_dec
      assign hit[gi] = (rxCode == encNib(NIB_W'(gi)));
    end
  endgenerate

  always_comb begin
    decNib = '0;
    for (int i = 0; i < NUM_DATA; i++)
      if (hit[i]) decNib = NIB_W'(i);
  end

  assign rxClass.isJ    = (rxCode == C_J);
  assign rxClass.isK    = (rxCode == C_K);
  assign rxClass.isT    = (rxCode == C_T);
  assign rxClass.isIdle = (rxCode == C_IDLE);
  assign rxClass.isData = |hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCode <= C_IDLE;
    end else begin
      case (strobes.txSel)
        TXO_J:    txCode <= C_J;
        TXO_K:    txCode <= C_K;
        TXO_DATA: txCode <= encNib(txd);
        TXO_ERR:  txCode <= C_H;
        TXO_T:    txCode <= C_T;
        TXO_R:    txCode <= C_R;
        default:  txCode <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crs <= 1'b0; rxDv <= 1'b0; rxEr <= 1'b0; rxd <= '0;
    end else begin
      case (strobes.rxSel)
        RXO_PRE:   begin crs <= 1'b1; rxDv <= 1'b1; rxEr <= 1'b0; rxd <= PRE_NIB; end
        RXO_DATA:  begin crs <= 1'b1; rxDv <= 1'b1; rxEr <= 1'b0; rxd <= decNib;  end
        RXO_BAD:   begin crs <= 1'b1; rxDv <= 1'b1; rxEr <= 1'b1; rxd <= '0;      end
        RXO_EARLY: begin crs <= 1'b0; rxDv <= 1'b0; rxEr <= 1'b1; rxd <= '0;      end
        default:   begin crs <= 1'b0; rxDv <= 1'b0; rxEr <= 1'b0; rxd <= '0;      end
      endcase
    end
  end

  AST_J_THEN_K: assert property (@(posedge clk) disable iff (!rstN)
    (txCode == C_J) |=> (txCode == C_K)); // R2
  AST_T_THEN_R: assert property (@(posedge clk) disable iff (!rstN)
    (txCode == C_T) |=> (txCode == C_R)); // R5
  AST_EARLY_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (rxEr && !crs) |=> !rxEr); // R9
endmodule

// File: rtl/pcs_framer.sv
module pcs_framer
  import pcs_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              txEr,
  input  logic [NIB_W-1:0]  txd,
  output logic [CODE_W-1:0] txCode,
  input  logic [CODE_W-1:0] rxCode,
  output logic              crs,
  output logic              rxDv,
  output logic              rxEr,
  output logic [NIB_W-1:0]  rxd
);
  strobes_t strobes;
  rxClass_t rxClass;

  pcs_framer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr),
    .rxClass(rxClass), .strobes(strobes)
  );

  pcs_framer_dp u_dp (
    .clk(clk), .rstN(rstN), .txd(txd), .rxCode(rxCode), .strobes(strobes),
    .rxClass(rxClass), .txCode(txCode), .crs(crs), .rxDv(rxDv),
    .rxEr(rxEr), .rxd(rxd)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txCode == C_IDLE && !txEn) |=> (txCode == C_IDLE)); // R1
  AST_DV_NEEDS_CRS: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |-> crs); // R6
endmodule

// File: tb/pcs_framer_bench.sv
module pcs_framer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b0, txEr = 1'b0;
  logic [3:0] txd = '0;
  logic [4:0] txCode, rxCode;
  logic crs, rxDv, rxEr;
  logic [3:0] rxd;
  int total = 0, bad = 0;
  bit timedOut = 1'b0;

  localparam logic [4:0] K_IDLE = 5'b11111, K_J = 5'b11000, K_K = 5'b10001;
  localparam logic [4:0] K_T = 5'b01101, K_R = 5'b00111, K_H = 5'b00100;
  logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};

  always #10 clk = ~clk;

  pcs_framer u_pcs_framer (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txd(txd),
    .txCode(txCode), .rxCode(rxCode), .crs(crs), .rxDv(rxDv),
    .rxEr(rxEr), .rxd(rxd)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chkTx(input string req, input logic [4:0] exp);
    total++;
    if (txCode !== exp) begin
      bad++;
      $display("FAIL %s txCode act=%b exp=%b", req, txCode, exp);
    end
  endtask

  task automatic chkRx(input string req, input logic c, input logic d,
                       input logic e, input logic [3:0] n);
    total++;
    if ({crs, rxDv, rxEr, rxd} !== {c, d, e, n}) begin
      bad++;
      $display("FAIL %s rx act=%b%b%b/%h exp=%b%b%b/%h", req, crs, rxDv, rxEr, rxd, c, d, e, n);
    end
  endtask

  function automatic int dataIdx(input logic [4:0] c);
    for (int i = 0; i < 16; i++) if (tbl[i] == c) return i;
    return -1;
  endfunction

  task automatic rxStart();
    rxCode = K_J; tick(); chkRx("R6 J", 1, 1, 0, 4'b0101);
    rxCode = K_K; tick(); chkRx("R6 K", 1, 1, 0, 4'b0101);
  endtask

  initial begin
    #2000000;
    timedOut = 1'b1;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rxCode = K_IDLE;
    tick(); tick();
    chkTx("R1 reset", K_IDLE);
    chkRx("R1 reset", 0, 0, 0, 4'h0);
    rstN = 1'b1;
    tick(); tick();
    chkTx("R1 idle", K_IDLE);

    // Transmit: one frame per error position, data sweep of all 16 nibbles
    for (int f = 0; f < 17; f++) begin
      txEn = 1'b1; txd = 4'h5; tick(); chkTx("R2 J", K_J);
      tick(); chkTx("R2 K", K_K);
      for (int n = 0; n < 16; n++) begin
        txd = 4'(n); txEr = (n == f);
        tick();
        if (n == f) chkTx("R4 H", K_H);
        else        chkTx("R3 data", tbl[n]);
      end
      txEn = 1'b0; txEr = 1'b0;
      tick(); chkTx("R5 T", K_T);
      tick(); chkTx("R5 R", K_R);
      tick(); chkTx("R5 idle after", K_IDLE);
      tick(); chkTx("R1 idle gap", K_IDLE);
    end

    // Receive: outside a frame nothing but J has effect
    for (int c = 0; c < 32; c++) begin
      if (5'(c) == K_J) continue;
      rxCode = 5'(c); tick(); chkRx("R11 outside", 0, 0, 0, 4'h0);
    end

    // Receive: every code value inside a frame
    rxCode = K_IDLE; tick();
    rxStart();
    for (int c = 0; c < 32; c++) begin
      int di;
      rxCode = 5'(c); tick();
      di = dataIdx(5'(c));
      if (di >= 0) chkRx("R7 data", 1, 1, 0, 4'(di));
      else if (5'(c) == K_T) begin
        chkRx("R8 T", 0, 0, 0, 4'h0);
        rxCode = K_R; tick(); chkRx("R8 R", 0, 0, 0, 4'h0);
        rxCode = K_IDLE; tick(); chkRx("R8 idle", 0, 0, 0, 4'h0);
        rxStart();
      end else if (5'(c) == K_IDLE) begin
        chkRx("R9 early", 0, 0, 1, 4'h0);
        tick(); chkRx("R9 one clock", 0, 0, 0, 4'h0);
        rxStart();
      end else chkRx("R10 invalid", 1, 1, 1, 4'h0);
    end
    rxCode = K_T; tick(); chkRx("R8 T", 0, 0, 0, 4'h0);
    rxCode = K_R; tick(); chkRx("R8 R", 0, 0, 0, 4'h0);
    rxCode = K_IDLE; tick();

    // Receive: non-K after J
    rxCode = K_J; tick(); chkRx("R6 J", 1, 1, 0, 4'b0101);
    rxCode = tbl[3]; tick(); chkRx("R10 no K", 1, 1, 1, 4'h0);
    rxCode = tbl[9]; tick(); chkRx("R7 after", 1, 1, 0, 4'h9);
    rxCode = K_IDLE; tick(); chkRx("R9 early", 0, 0, 1, 4'h0);
    tick(); chkRx("R9 one clock", 0, 0, 0, 4'h0);

    if (!timedOut) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule